// File: doc/BRIEF.md
# Palette and Pixel Format Unpacker

This block turns a stream of 32-bit frame-buffer words into 24-bit RGB pixels for one scan line. A depth code picks the pixel size: 1, 2, 4 and 8 bits per pixel are indices into an internal 256-entry colour table, while 16-bit, 12-bit and 32-bit pixels carry their colour directly. Colour table writes arrive as 32-bit words, and each word fills two adjacent 15-bit entries.

A line begins with a one-cycle `line_start` pulse. The block then fetches words through a valid/ready handshake and emits one pixel per cycle on `pix_valid`/`pix_rgb` until the configured column count is reached. Three settings control how pixels are read: a red/blue swap, a big-endian byte order, and a big-endian pixel order within each byte. An external two-bit selector chooses between the 16-bit layouts.

The control is a three-state machine. ST_IDLE moves to ST_FETCH on `line_start` when the column count is non-zero. ST_FETCH moves to ST_EMIT when a word is accepted. ST_EMIT returns to ST_FETCH after the last pixel of a word, and to ST_IDLE after the last column of the line. In every other cycle it stays in ST_EMIT and advances to the next pixel slot.

Top module: `pixel_unpacker`

## Requirements
- R1: After reset, `in_ready` and `pix_valid` are both 0.
- R2: A `line_start` pulse with a non-zero column count raises `in_ready` in the next cycle. A word accepted with `in_valid` and `in_ready` high produces its first pixel in the next cycle. `in_ready` stays low while the pixels of a word are being emitted.
- R3: A colour table write to word n sets entry 2n from bits [14:0] and entry 2n+1 from bits [30:16]. Bits 15 and 31 are ignored. Within an entry, red is [4:0], green is [9:5] and blue is [14:10], and each is shifted left by 3 on output. `pix_rgb` carries red in [23:16], green in [15:8] and blue in [7:0].
- R4: Each depth code fixes the number of pixels in a word, emitted on consecutive cycles. The codes are 0 = 1 bpp (32 pixels), 1 = 2 bpp (16), 2 = 4 bpp (8), 3 = 8 bpp (4), 4 and 6 = 16 bpp (2), 7 = 12 bpp (2) and 5 = 32 bpp (1).
- R5: With both order bits clear, pixel k of a word at b bits per pixel is bits [k*b+b-1 : k*b].
- R6: With only the pixel-order bit set, pixels below 8 bpp are taken from the most significant end of each byte, with bytes in ascending order. From 8 bpp upward, this bit changes nothing.
- R7: With the byte-order bit set, the word is byte-reversed and pixels are then taken from its most significant end. This bit overrides the pixel-order bit when both are set.
- R8: Depth 6 is 565, with red in [4:0], green in [10:5] and blue in [15:11]. The 6-bit green is shifted left by 2. Depth 4 follows the selector: 1 gives 5551 (same layout as a table entry), 0 and 2 give 565, and 3 gives 565 with red and blue swapped whatever the swap bit is.
- R9: Depth 7 reads red, green and blue from [3:0], [7:4] and [11:8] of each halfword, each shifted left by 4, and ignores bits [15:12]. Depth 5 reads red, green and blue from [7:0], [15:8] and [23:16].
- R10: When the swap bit is set, the red and blue output bytes are exchanged.
- R11: After the configured number of columns, the block returns to idle with `in_ready` low and discards the remaining pixels of the word. A `line_start` with a column count of 0 starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pal_we | input | 1 | Colour table word write strobe |
| pal_word | input | 7 | Colour table word index n (entries 2n, 2n+1) |
| pal_wdata | input | 32 | Two packed 15-bit colour entries |
| cfg_depth | input | 3 | Depth code |
| cfg_bgr | input | 1 | Swap red and blue on output |
| cfg_be_byte | input | 1 | Big-endian byte order |
| cfg_be_pix | input | 1 | Big-endian pixel order within bytes |
| fmt16_sel | input | 2 | 16-bit layout selector for depth code 4 |
| cfg_cols | input | COL_W | Pixels per line |
| line_start | input | 1 | Begin a line |
| in_valid | input | 1 | Input word valid |
| in_data | input | 32 | Frame-buffer word |
| in_ready | output | 1 | Block can accept a word |
| pix_valid | output | 1 | Pixel strobe |
| pix_rgb | output | 24 | Pixel colour, red in the top byte |

## Verification
The bench builds the block with COL_W = 6. Column counts then reach 63, which covers a full 32-pixel word at 1 bpp, lines that span two words at 8 bpp, and lines cut short in the middle of a word. A stimulus table walks every depth code under each order bit, every selector value and the swap bit, against colour table entries that have their ignored bits set. Directed tests then cover reset, a zero column count and the handshake across word boundaries.

// File: rtl/pxu_pkg.sv
package pxu_pkg;
    localparam int WORD_W      = 32;
    localparam int PAL_ENTRIES = 256;
    localparam int PAL_IDX_W   = $clog2(PAL_ENTRIES);
    localparam int PAL_WORD_AW = PAL_IDX_W - 1;
    localparam int SLOT_W      = $clog2(WORD_W);
    localparam int SHIFT_W     = SLOT_W + 1;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_EMIT  = 2'd2
    } pxu_state_t;

    // log2 of bits per pixel for each depth code
    function automatic logic [2:0] depth_log2(input logic [2:0] d);
        unique case (d)
            3'd0: depth_log2 = 3'd0;
            3'd1: depth_log2 = 3'd1;
            3'd2: depth_log2 = 3'd2;
            3'd3: depth_log2 = 3'd3;
            3'd5: depth_log2 = 3'd5;
            default: depth_log2 = 3'd4;
        endcase
    endfunction
endpackage

// File: rtl/pxu_palette.sv
module pxu_palette
    import pxu_pkg::*;
(
    input  logic                   clk,
    input  logic                   we,
    input  logic [PAL_WORD_AW-1:0] waddr,
    input  logic [WORD_W-1:0]      wdata,
    input  logic [PAL_IDX_W-1:0]   ridx,
    output logic [14:0]            rentry
);
    logic [14:0] mem [PAL_ENTRIES];

    // one word fills an even/odd pair; the top bit of each half is dropped
    always_ff @(posedge clk) begin
        if (we) begin
            mem[{waddr, 1'b0}] <= wdata[14:0];
            mem[{waddr, 1'b1}] <= wdata[30:16];
        end
    end

    assign rentry = mem[ridx];
endmodule

// File: rtl/pxu_extract.sv
module pxu_extract
    import pxu_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic [2:0]        lb,
    input  logic [SLOT_W-1:0] slot,
    input  logic              be_byte,
    input  logic              be_pix,
    output logic [WORD_W-1:0] field
);
    localparam int NBYTES = WORD_W / 8;

    logic [WORD_W-1:0]  swapped;
    logic [WORD_W-1:0]  src;
    logic [SHIFT_W-1:0] bits;
    logic [SHIFT_W-1:0] off;
    logic [SHIFT_W-1:0] sh;

    for (genvar i = 0; i < NBYTES; i++) begin : g_rev
        assign swapped[8*i +: 8] = word[8*(NBYTES-1-i) +: 8];
    end

    always_comb begin
        bits = SHIFT_W'(1) << lb;
        off  = SHIFT_W'(slot) << lb;
        src  = word;
        sh   = off;
        if (be_byte) begin
            src = swapped;
            sh  = SHIFT_W'(WORD_W) - bits - off;
        end else if (be_pix && lb < 3'd3) begin
            sh = (off & ~SHIFT_W'(7)) + (SHIFT_W'(8) - bits - (off & SHIFT_W'(7)));
        end
        field = (src >> sh) & ~({WORD_W{1'b1}} << bits);
    end
endmodule

// File: rtl/pxu_colour.sv
module pxu_colour
    import pxu_pkg::*;
(
    input  logic [2:0]        depth,
    input  logic [1:0]        sel16,
    input  logic              bgr,
    input  logic [WORD_W-1:0] field,
    input  logic [14:0]       entry,
    output logic [23:0]       rgb
);
    logic [7:0] r, g, b;
    logic       swap;

    always_comb begin
        r = '0;
        g = '0;
        b = '0;
        unique case (depth)
            3'd0, 3'd1, 3'd2, 3'd3: begin
                r = {entry[4:0], 3'b0};
                g = {entry[9:5], 3'b0};
                b = {entry[14:10], 3'b0};
            end
            3'd4: begin
                if (sel16 == 2'd1) begin
                    r = {field[4:0], 3'b0};
                    g = {field[9:5], 3'b0};
                    b = {field[14:10], 3'b0};
                end else begin
                    r = {field[4:0], 3'b0};
                    g = {field[10:5], 2'b0};
                    b = {field[15:11], 3'b0};
                end
            end
            3'd5: begin
                r = field[7:0];
                g = field[15:8];
                b = field[23:16];
            end
            3'd6: begin
                r = {field[4:0], 3'b0};
                g = {field[10:5], 2'b0};
                b = {field[15:11], 3'b0};
            end
            default: begin
                r = {field[3:0], 4'b0};
                g = {field[7:4], 4'b0};
                b = {field[11:8], 4'b0};
            end
        endcase
        swap = bgr || (depth == 3'd4 && sel16 == 2'd3);
        rgb  = swap ? {b, g, r} : {r, g, b};
    end
endmodule

// File: rtl/pixel_unpacker.sv
module pixel_unpacker
    import pxu_pkg::*;
#(
    parameter int COL_W = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   pal_we,
    input  logic [PAL_WORD_AW-1:0] pal_word,
    input  logic [WORD_W-1:0]      pal_wdata,
    input  logic [2:0]             cfg_depth,
    input  logic                   cfg_bgr,
    input  logic                   cfg_be_byte,
    input  logic                   cfg_be_pix,
    input  logic [1:0]             fmt16_sel,
    input  logic [COL_W-1:0]       cfg_cols,
    input  logic                   line_start,
    input  logic                   in_valid,
    input  logic [WORD_W-1:0]      in_data,
    output logic                   in_ready,
    output logic                   pix_valid,
    output logic [23:0]            pix_rgb
);
    pxu_state_t        state_q, state_d;
    logic [WORD_W-1:0] word_q;
    logic [SLOT_W-1:0] slot_q;
    logic [COL_W-1:0]  left_q;

    logic [2:0]        lb;
    logic [SLOT_W-1:0] last_slot;
    logic [WORD_W-1:0] field;
    logic [14:0]       entry;
    logic [23:0]       rgb;

    assign lb        = depth_log2(cfg_depth);
    assign last_slot = {SLOT_W{1'b1}} >> lb;

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (line_start && cfg_cols != '0) state_d = ST_FETCH;
            ST_FETCH: if (in_valid) state_d = ST_EMIT;
            ST_EMIT: begin
                if (left_q == COL_W'(1))      state_d = ST_IDLE;
                else if (slot_q == last_slot) state_d = ST_FETCH;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and per-line counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            word_q  <= '0;
            slot_q  <= '0;
            left_q  <= '0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                ST_IDLE: if (line_start) left_q <= cfg_cols;
                ST_FETCH: if (in_valid) begin
                    word_q <= in_data;
                    slot_q <= '0;
                end
                ST_EMIT: begin
                    left_q <= left_q - COL_W'(1);
                    slot_q <= slot_q + SLOT_W'(1);
                end
                default: ;
            endcase
        end
    end

    pxu_extract u_extract (
        .word    (word_q),
        .lb      (lb),
        .slot    (slot_q),
        .be_byte (cfg_be_byte),
        .be_pix  (cfg_be_pix),
        .field   (field)
    );

    pxu_palette u_palette (
        .clk    (clk),
        .we     (pal_we),
        .waddr  (pal_word),
        .wdata  (pal_wdata),
        .ridx   (field[PAL_IDX_W-1:0]),
        .rentry (entry)
    );

    pxu_colour u_colour (
        .depth (cfg_depth),
        .sel16 (fmt16_sel),
        .bgr   (cfg_bgr),
        .field (field),
        .entry (entry),
        .rgb   (rgb)
    );

    // outputs decoded from the state
    always_comb begin
        in_ready  = (state_q == ST_FETCH);
        pix_valid = (state_q == ST_EMIT);
        pix_rgb   = pix_valid ? rgb : '0;
    end
endmodule

// File: rtl/pixel_unpacker_chk.sv
module pixel_unpacker_chk #(
    parameter int COL_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             line_start,
    input logic [COL_W-1:0] cfg_cols,
    input logic [2:0]       cfg_depth,
    input logic             cfg_bgr,
    input logic             cfg_be_byte,
    input logic             in_valid,
    input logic             in_ready,
    input logic             pix_valid,
    input logic [23:0]      pix_rgb,
    input logic [31:0]      word_q
);
    p_start_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        line_start && cfg_cols != '0 && !in_ready && !pix_valid |=> in_ready);

    p_accept_emit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> pix_valid && !in_ready);

    p_zero_cols_r11: assert property (@(posedge clk) disable iff (!rst_n)
        line_start && cfg_cols == '0 && !in_ready && !pix_valid |=> !in_ready && !pix_valid);

    p_single32_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid && cfg_depth == 3'd5 |=> !pix_valid);

    p_direct32_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid && cfg_depth == 3'd5 && !cfg_bgr && !cfg_be_byte
        |-> pix_rgb == {word_q[7:0], word_q[15:8], word_q[23:16]});
endmodule

bind pixel_unpacker pixel_unpacker_chk #(.COL_W(COL_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_start  (line_start),
    .cfg_cols    (cfg_cols),
    .cfg_depth   (cfg_depth),
    .cfg_bgr     (cfg_bgr),
    .cfg_be_byte (cfg_be_byte),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .pix_valid   (pix_valid),
    .pix_rgb     (pix_rgb),
    .word_q      (word_q)
);

// File: tb/sim_pixel_unpacker.sv
`timescale 1ns/1ps
module sim_pixel_unpacker;
    localparam int COL_W = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pal_we = 1'b0;
    logic [6:0]  pal_word = '0;
    logic [31:0] pal_wdata = '0;
    logic [2:0]  cfg_depth = '0;
    logic        cfg_bgr = 1'b0, cfg_be_byte = 1'b0, cfg_be_pix = 1'b0;
    logic [1:0]  fmt16_sel = '0;
    logic [COL_W-1:0] cfg_cols = '0;
    logic        line_start = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_ready, pix_valid;
    logic [23:0] pix_rgb;

    always #2.5 clk = ~clk;

    pixel_unpacker #(.COL_W(COL_W)) u0 (
        .clk, .rst_n, .pal_we, .pal_word, .pal_wdata, .cfg_depth, .cfg_bgr,
        .cfg_be_byte, .cfg_be_pix, .fmt16_sel, .cfg_cols, .line_start,
        .in_valid, .in_data, .in_ready, .pix_valid, .pix_rgb
    );

    int total = 0, bad = 0, cnt = 0, overlap = 0;
    bit done = 1'b0;
    logic [23:0] cap [64];

    always @(negedge clk) begin
        if (pix_valid) begin
            if (cnt < 64) cap[cnt] = pix_rgb;
            cnt = cnt + 1;
            if (in_ready) overlap = overlap + 1;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    typedef struct packed {
        logic [2:0]  depth;
        logic        bgr, beb, bep;
        logic [1:0]  mux;
        logic [5:0]  cols;
        logic [31:0] word;
        logic [4:0]  k;
        logic [23:0] exp;
        logic [5:0]  cnt;
    } vec_t;

    localparam int NV = 28;
    localparam vec_t VEC [NV] = '{
        '{3'd0,1'b0,1'b0,1'b0,2'd0,6'd8, 32'h00000002,5'd1,24'hF80080,6'd8},  // R5
        '{3'd0,1'b0,1'b0,1'b0,2'd0,6'd8, 32'h00000002,5'd0,24'h081018,6'd8},  // R3 bit 15 set
        '{3'd0,1'b0,1'b0,1'b1,2'd0,6'd8, 32'h00000040,5'd1,24'hF80080,6'd8},  // R6
        '{3'd0,1'b0,1'b1,1'b1,2'd0,6'd8, 32'h00000040,5'd1,24'hF80080,6'd8},  // R7
        '{3'd1,1'b0,1'b0,1'b0,2'd0,6'd16,32'h000000E4,5'd2,24'h202830,6'd16}, // R5
        '{3'd1,1'b0,1'b0,1'b1,2'd0,6'd16,32'h000000E4,5'd0,24'h00F800,6'd16}, // R6
        '{3'd2,1'b0,1'b0,1'b0,2'd0,6'd8, 32'h00000030,5'd1,24'h00F800,6'd8},  // R5
        '{3'd2,1'b0,1'b0,1'b1,2'd0,6'd8, 32'h00000030,5'd0,24'h00F800,6'd8},  // R6
        '{3'd3,1'b0,1'b0,1'b0,2'd0,6'd4, 32'hFEFF0201,5'd3,24'hF8F8F8,6'd4},  // R4
        '{3'd3,1'b0,1'b1,1'b0,2'd0,6'd4, 32'hFEFF0201,5'd1,24'h202830,6'd4},  // R7
        '{3'd5,1'b0,1'b0,1'b0,2'd0,6'd1, 32'h00332211,5'd0,24'h112233,6'd1},  // R9
        '{3'd5,1'b0,1'b1,1'b0,2'd0,6'd1, 32'h11223344,5'd0,24'h112233,6'd1},  // R7
        '{3'd5,1'b1,1'b0,1'b0,2'd0,6'd1, 32'h00332211,5'd0,24'h332211,6'd1},  // R10
        '{3'd6,1'b0,1'b0,1'b0,2'd0,6'd2, 32'h07E0001F,5'd0,24'hF80000,6'd2},  // R8
        '{3'd6,1'b0,1'b0,1'b0,2'd0,6'd2, 32'h07E0001F,5'd1,24'h00FC00,6'd2},  // R8
        '{3'd6,1'b0,1'b1,1'b1,2'd0,6'd2, 32'h07E0001F,5'd0,24'h00E018,6'd2},  // R7 precedence
        '{3'd6,1'b0,1'b0,1'b1,2'd0,6'd2, 32'h07E0001F,5'd0,24'hF80000,6'd2},  // R6
        '{3'd4,1'b0,1'b0,1'b0,2'd1,6'd2, 32'h00007C00,5'd0,24'h0000F8,6'd2},  // R8 5551
        '{3'd4,1'b0,1'b0,1'b0,2'd0,6'd2, 32'h00007C00,5'd0,24'h008078,6'd2},  // R8 565
        '{3'd4,1'b0,1'b0,1'b0,2'd3,6'd2, 32'h0000001F,5'd0,24'h0000F8,6'd2},  // R8 forced swap
        '{3'd4,1'b0,1'b0,1'b0,2'd2,6'd2, 32'h0000001F,5'd0,24'hF80000,6'd2},  // R8
        '{3'd4,1'b1,1'b0,1'b0,2'd2,6'd2, 32'h0000001F,5'd0,24'h0000F8,6'd2},  // R10
        '{3'd4,1'b1,1'b0,1'b0,2'd3,6'd2, 32'h0000001F,5'd0,24'h0000F8,6'd2},  // R8
        '{3'd7,1'b0,1'b0,1'b0,2'd0,6'd2, 32'h0000FABC,5'd0,24'hC0B0A0,6'd2},  // R9
        '{3'd3,1'b1,1'b0,1'b0,2'd0,6'd4, 32'h00000001,5'd0,24'h8000F8,6'd4},  // R10
        '{3'd3,1'b0,1'b0,1'b0,2'd0,6'd2, 32'hFEFF0201,5'd1,24'h202830,6'd2},  // R11
        '{3'd0,1'b0,1'b0,1'b0,2'd0,6'd3, 32'h00000002,5'd1,24'hF80080,6'd3},  // R11
        '{3'd3,1'b0,1'b0,1'b0,2'd0,6'd1, 32'h000000FF,5'd0,24'h101010,6'd1}   // R3 odd entry
    };

    task automatic pal_write(input logic [6:0] n, input logic [31:0] d);
        @(negedge clk);
        pal_we = 1'b1; pal_word = n; pal_wdata = d;
        @(negedge clk);
        pal_we = 1'b0;
    endtask

    task automatic start_line(input logic [5:0] cols);
        @(negedge clk);
        cfg_cols = cols;
        cnt = 0;
        overlap = 0;
        line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
    endtask

    task automatic send_word(input logic [31:0] w);
        int guard = 0;
        while (!in_ready && guard < 100) begin
            @(negedge clk);
            guard++;
        end
        in_valid = 1'b1; in_data = w;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic settle();
        repeat (40) @(negedge clk);
    endtask

    initial begin
        #400000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 in_ready", 32'(in_ready), 32'd0);
        check("R1 pix_valid", 32'(pix_valid), 32'd0);
        rst_n = 1'b1;

        pal_write(7'd0, 32'h401F_8C41);
        pal_write(7'd1, 32'h03E0_18A4);
        pal_write(7'h7F, 32'h0842_7FFF);

        for (int i = 0; i < NV; i++) begin
            cfg_depth = VEC[i].depth; cfg_bgr = VEC[i].bgr;
            cfg_be_byte = VEC[i].beb; cfg_be_pix = VEC[i].bep;
            fmt16_sel = VEC[i].mux;
            start_line(VEC[i].cols);
            send_word(VEC[i].word);
            settle();
            check($sformatf("vector %0d pixel", i), 32'(cap[VEC[i].k]), 32'(VEC[i].exp));
            check($sformatf("vector %0d count R4/R11", i), 32'(cnt), 32'(VEC[i].cnt));
            check($sformatf("vector %0d idle R11", i), 32'(in_ready), 32'd0);
        end

        // R2: handshake over two words at 8 bpp, R11 end mid word
        cfg_depth = 3'd3; cfg_bgr = 1'b0; cfg_be_byte = 1'b0; cfg_be_pix = 1'b0;
        start_line(6'd6);
        check("R2 ready after start", 32'(in_ready), 32'd1);
        send_word(32'h0302_0100);
        check("R2 first pixel next cycle", 32'(pix_valid), 32'd1);
        send_word(32'h0000_0302);
        settle();
        check("R2 two-word count", 32'(cnt), 32'd6);
        check("R2 pixel 4", 32'(cap[4]), 32'h202830);
        check("R2 pixel 5", 32'(cap[5]), 32'h00F800);
        check("R2 pixel 3", 32'(cap[3]), 32'h00F800);
        check("R2 no ready while emitting", 32'(overlap), 32'd0);

        // R11: zero columns starts nothing
        start_line(6'd0);
        check("R11 zero cols ready", 32'(in_ready), 32'd0);
        repeat (3) @(negedge clk);
        check("R11 zero cols pixels", 32'(cnt), 32'd0);

        // R4: full 1 bpp word, all 32 pixels
        cfg_depth = 3'd0;
        start_line(6'd32);
        send_word(32'h8000_0001);
        settle();
        check("R4 32 pixels", 32'(cnt), 32'd32);
        check("R4 last pixel", 32'(cap[31]), 32'hF80080);
        check("R4 middle pixel", 32'(cap[15]), 32'h081018);

        // R1: reset in the middle of a line
        start_line(6'd8);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset ready", 32'(in_ready), 32'd0);
        check("R1 reset valid", 32'(pix_valid), 32'd0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule